// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Unit

This unit produces the single interrupt line of a byte-oriented SPI controller. The controller's transmit and receive FIFOs are 32 entries deep. The unit gets three things from outside: the occupancy count of each FIFO, one-cycle pulses for three error events, and a plain register port for writes and combinational reads. It does not model the FIFOs, the shifter or the chip selects.

The seven-bit status word mixes two kinds of bit. Three error bits latch when their event occurs and stay set until software writes 1 to their positions. The other four bits are live: each cycle they are derived from the occupancy counts and two programmable thresholds. Software cannot write the interrupt mask directly. It sets mask bits through an enable register and clears them through a disable register. The interrupt output is high whenever any status bit is high and its mask bit is also high.

Status bit positions: 6 = transmit underflow (latched), 5 = receive full, 4 = receive at or above threshold, 3 = transmit full, 2 = transmit below threshold, 1 = mode fault (latched), 0 = receive overflow (latched).

Register select codes on `reg_addr`: 0 = status, 1 = mask enable, 2 = mask disable, 3 = mask, 4 = transmit threshold, 5 = receive threshold. Codes 6 and 7 read as zero and ignore writes.

Top module: `spi_irq_status_unit`

## Requirements
- R1: After reset the mask and all three latched bits are 0, and both thresholds read 1.
- R2: A pulse on `ev_tx_underrun`, `ev_mode_fault` or `ev_rx_overrun` sets status bit 6, 1 or 0 respectively from the next cycle. The bit then stays set while no clear is written.
- R3: A write to status code 0 clears exactly those latched bits whose positions in `wr_data` hold 1. Bits written with 0 keep their value. Writes to the live bits 5, 4, 3 and 2 have no effect.
- R4: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Status bit 4 is 1 exactly when `rx_count` is greater than or equal to the receive threshold.
- R6: Status bit 2 is 1 exactly when `tx_count` is strictly less than the transmit threshold.
- R7: Status bit 5 is 1 exactly when `rx_count` equals 32. Status bit 3 is 1 exactly when `tx_count` equals 32.
- R8: A write to code 1 ORs `wr_data[6:0]` into the mask.
- R9: A write to code 2 clears every mask bit where `wr_data[6:0]` holds 1.
- R10: Codes 1 and 2 always read 0. A write to code 3 leaves the mask unchanged.
- R11: `irq` is 1 exactly when some bit is 1 in both the mask and the status word.
- R12: The thresholds are 6 bits wide and store any written value, including values above 32. A threshold of 0 makes bit 4 always 1 and bit 2 always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_count | input | 6 | Transmit FIFO occupancy, 0 to 32 |
| rx_count | input | 6 | Receive FIFO occupancy, 0 to 32 |
| ev_tx_underrun | input | 1 | Pulse: transmit FIFO underflow |
| ev_mode_fault | input | 1 | Pulse: mode fault |
| ev_rx_overrun | input | 1 | Pulse: receive FIFO overflow |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select code |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that the occupancy inputs never exceed the FIFO depth of 32, and one property checks exactly that on the inputs. The random stimulus draws counts only from 0 to 32 and hits both ends often. Event pulses and register writes are drawn independently of each other. This lets event/clear collisions, writes to read-only codes and out-of-range threshold values all occur, and the properties must hold for every combination.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    parameter int FIFO_DEPTH = 32;
    parameter int DATA_W     = 32;
    parameter int STAT_W     = 7;
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
    localparam int ADDR_W    = 3;

    // Status bit positions (software decodes these)
    localparam int B_TX_UNDER = 6;
    localparam int B_RX_FULL  = 5;
    localparam int B_RX_THR   = 4;
    localparam int B_TX_FULL  = 3;
    localparam int B_TX_THR   = 2;
    localparam int B_MODE_F   = 1;
    localparam int B_RX_OVER  = 0;

    localparam logic [STAT_W-1:0] LATCHED_BITS =
        STAT_W'((1 << B_TX_UNDER) | (1 << B_MODE_F) | (1 << B_RX_OVER));

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_ENABLE = 3'd1,
        SEL_DISABLE= 3'd2,
        SEL_MASK   = 3'd3,
        SEL_TX_THR = 3'd4,
        SEL_RX_THR = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] q_o
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (LATCHED_BITS[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_i[i])
                    bit_q <= 1'b1;      // set beats clear
                else if (clr_i[i])
                    bit_q <= 1'b0;
            end
            assign q_o[i] = bit_q;
        end else begin : g_none
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import spi_irq_pkg::*;
(
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_thr,
    input  logic [CNT_W-1:0]  rx_thr,
    output logic [STAT_W-1:0] live_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    always_comb begin
        live_o             = '0;
        live_o[B_RX_FULL]  = (rx_count == FULL_CNT);
        live_o[B_RX_THR]   = (rx_count >= rx_thr);
        live_o[B_TX_FULL]  = (tx_count == FULL_CNT);
        live_o[B_TX_THR]   = (tx_count <  tx_thr);
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STAT_W-1:0] mask_o,
    output logic [CNT_W-1:0]  tx_thr_o,
    output logic [CNT_W-1:0]  rx_thr_o
);
    localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(1);

    logic [STAT_W-1:0] mask_d;
    logic [CNT_W-1:0]  tx_thr_d, rx_thr_d;

    always_comb begin
        mask_d   = mask_o;
        tx_thr_d = tx_thr_o;
        rx_thr_d = rx_thr_o;
        if (wr_en) begin
            unique case (sel)
                SEL_ENABLE:  mask_d   = mask_o | wr_data[STAT_W-1:0];
                SEL_DISABLE: mask_d   = mask_o & ~wr_data[STAT_W-1:0];
                SEL_TX_THR:  tx_thr_d = wr_data[CNT_W-1:0];
                SEL_RX_THR:  rx_thr_d = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o   <= '0;
            tx_thr_o <= THR_RESET;
            rx_thr_o <= THR_RESET;
        end else begin
            mask_o   <= mask_d;
            tx_thr_o <= tx_thr_d;
            rx_thr_o <= rx_thr_d;
        end
    end
endmodule

// File: rtl/spi_irq_status_unit.sv
module spi_irq_status_unit
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              ev_tx_underrun,
    input  logic              ev_mode_fault,
    input  logic              ev_rx_overrun,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    reg_sel_e          sel;
    logic [STAT_W-1:0] ev_vec, clr_vec, sticky_q, live_vec, status_w, mask_q;
    logic [CNT_W-1:0]  tx_thr_q, rx_thr_q;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        ev_vec             = '0;
        ev_vec[B_TX_UNDER] = ev_tx_underrun;
        ev_vec[B_MODE_F]   = ev_mode_fault;
        ev_vec[B_RX_OVER]  = ev_rx_overrun;
        clr_vec = (wr_en && sel == SEL_STATUS) ?
                  (wr_data[STAT_W-1:0] & LATCHED_BITS) : '0;
    end

    irq_latch_bank u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_vec),
        .clr_i (clr_vec),
        .q_o   (sticky_q)
    );

    irq_level_eval u_level (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .live_o   (live_vec)
    );

    irq_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wr_data  (wr_data),
        .mask_o   (mask_q),
        .tx_thr_o (tx_thr_q),
        .rx_thr_o (rx_thr_q)
    );

    assign status_w = sticky_q | live_vec;
    assign irq      = |(mask_q & status_w);

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_STATUS: rd_data[STAT_W-1:0] = status_w;
            SEL_MASK:   rd_data[STAT_W-1:0] = mask_q;
            SEL_TX_THR: rd_data[CNT_W-1:0]  = tx_thr_q;
            SEL_RX_THR: rd_data[CNT_W-1:0]  = rx_thr_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
    import spi_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              ev_tx_underrun,
    input logic              ev_mode_fault,
    input logic              ev_rx_overrun,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [STAT_W-1:0] mask_q,
    input logic [STAT_W-1:0] sticky_q,
    input logic              irq
);
    // input assumption: counts within FIFO depth
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(FIFO_DEPTH)) && (rx_count <= CNT_W'(FIFO_DEPTH)));

    a_r2_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_underrun |=> sticky_q[B_TX_UNDER]);

    a_r4_overrun_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_overrun && wr_en && reg_addr == 3'd0 && wr_data[B_RX_OVER])
        |=> sticky_q[B_RX_OVER]);

    a_r3_modefault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q[B_MODE_F] && !(wr_en && reg_addr == 3'd0 && wr_data[B_MODE_F]))
        |=> sticky_q[B_MODE_F]);

    a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 3'd1)
        |=> ((mask_q & $past(wr_data[STAT_W-1:0])) == $past(wr_data[STAT_W-1:0])));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 3'd2) |=> ((mask_q & $past(wr_data[STAT_W-1:0])) == '0));

    a_r10_mask_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (reg_addr == 3'd1 || reg_addr == 3'd2)) |=> $stable(mask_q));

    a_r11_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

bind spi_irq_status_unit spi_irq_status_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_count       (tx_count),
    .rx_count       (rx_count),
    .ev_tx_underrun (ev_tx_underrun),
    .ev_mode_fault  (ev_mode_fault),
    .ev_rx_overrun  (ev_rx_overrun),
    .wr_en          (wr_en),
    .reg_addr       (reg_addr),
    .wr_data        (wr_data),
    .mask_q         (mask_q),
    .sticky_q       (sticky_q),
    .irq            (irq)
);

// File: tb/sim_spi_irq_status_unit.sv
`timescale 1ns/1ps
module sim_spi_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  tx_count = '0, rx_count = '0;
    logic        ev_tx_underrun = 0, ev_mode_fault = 0, ev_rx_overrun = 0;
    logic        wr_en = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model
    logic [6:0] m_mask, m_sticky;
    logic [5:0] m_txthr, m_rxthr;

    always #10 clk = ~clk;   // 50 MHz

    spi_irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
        .ev_tx_underrun(ev_tx_underrun), .ev_mode_fault(ev_mode_fault),
        .ev_rx_overrun(ev_rx_overrun), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [6:0] exp_status();
        logic [6:0] s;
        s    = m_sticky;
        s[5] = (rx_count == 6'd32);
        s[4] = (rx_count >= m_rxthr);
        s[3] = (tx_count == 6'd32);
        s[2] = (tx_count <  m_txthr);
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {25'd0, exp_status()};
            3'd3:    return {25'd0, m_mask};
            3'd4:    return {26'd0, m_txthr};
            3'd5:    return {26'd0, m_rxthr};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check pre-edge outputs, update model at posedge
    task automatic cyc(input string tag, input logic [5:0] tx, input logic [5:0] rx,
                       input logic [2:0] ev, input logic we, input logic [2:0] a,
                       input logic [31:0] d);
        logic [6:0] evv, clr;
        @(negedge clk);
        tx_count = tx; rx_count = rx;
        ev_tx_underrun = ev[2]; ev_mode_fault = ev[1]; ev_rx_overrun = ev[0];
        wr_en = we; reg_addr = a; wr_data = d;
        #2;
        check(tag, rd_data, exp_read(a));
        check("R11 irq", {31'd0, irq}, {31'd0, |(m_mask & exp_status())});
        @(posedge clk);
        evv = {ev[2], 4'b0000, ev[1], ev[0]};
        clr = (we && a == 3'd0) ? (d[6:0] & 7'b1000011) : 7'd0;
        m_sticky = evv | (m_sticky & ~clr);
        if (we) begin
            case (a)
                3'd1: m_mask = m_mask | d[6:0];
                3'd2: m_mask = m_mask & ~d[6:0];
                3'd4: m_txthr = d[5:0];
                3'd5: m_rxthr = d[5:0];
                default: ;
            endcase
        end
    endtask

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R3 status";
            3'd1, 3'd2: return "R10 enable/disable read";
            3'd3: return "R8 mask";
            3'd4, 3'd5: return "R12 threshold";
            default: return "R10 reserved";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        m_mask = '0; m_sticky = '0; m_txthr = 6'd1; m_rxthr = 6'd1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        cyc("R1 status", 6'd0, 6'd0, 3'b000, 0, 3'd0, 0);
        cyc("R1 mask",   6'd0, 6'd0, 3'b000, 0, 3'd3, 0);
        cyc("R1 txthr",  6'd0, 6'd0, 3'b000, 0, 3'd4, 0);
        cyc("R1 rxthr",  6'd0, 6'd0, 3'b000, 0, 3'd5, 0);
        // R2 latch and hold
        cyc("R2 pulse",  6'd5, 6'd0, 3'b101, 0, 3'd0, 0);
        cyc("R2 held",   6'd5, 6'd0, 3'b000, 0, 3'd0, 0);
        cyc("R2 held2",  6'd5, 6'd0, 3'b010, 0, 3'd0, 0);
        // R3 partial clear, live-bit write ignored
        cyc("R3 clr",    6'd5, 6'd0, 3'b000, 1, 3'd0, 32'h0000_003C | 32'h40);
        cyc("R3 after",  6'd5, 6'd0, 3'b000, 0, 3'd0, 0);
        // R4 set wins
        cyc("R4 both",   6'd5, 6'd0, 3'b001, 1, 3'd0, 32'h7F);
        cyc("R4 after",  6'd5, 6'd0, 3'b000, 0, 3'd0, 0);
        // R8 enable, R10 reads zero, R11 irq
        cyc("R8 en",     6'd5, 6'd0, 3'b000, 1, 3'd1, 32'hFFFF_FF01);
        cyc("R8 mask",   6'd5, 6'd0, 3'b000, 0, 3'd3, 0);
        cyc("R10 enrd",  6'd5, 6'd0, 3'b000, 0, 3'd1, 0);
        cyc("R10 mskwr", 6'd5, 6'd0, 3'b000, 1, 3'd3, 32'h7F);
        cyc("R10 mask",  6'd5, 6'd0, 3'b000, 0, 3'd3, 0);
        // R9 disable
        cyc("R9 dis",    6'd5, 6'd0, 3'b000, 1, 3'd2, 32'h1);
        cyc("R9 mask",   6'd5, 6'd0, 3'b000, 0, 3'd3, 0);
        cyc("R8 en all", 6'd5, 6'd0, 3'b000, 1, 3'd1, 32'h7F);
        // R5/R6/R7 boundaries
        cyc("R7 full",   6'd32, 6'd32, 3'b000, 0, 3'd0, 0);
        cyc("R5 eq",     6'd0, 6'd1, 3'b000, 0, 3'd0, 0);
        cyc("R6 eq",     6'd1, 6'd0, 3'b000, 0, 3'd0, 0);
        cyc("R7 31",     6'd31, 6'd31, 3'b000, 0, 3'd0, 0);
        // R12 large and zero thresholds
        cyc("R12 wr63",  6'd0, 6'd0, 3'b000, 1, 3'd4, 32'hFFFF_FFFF);
        cyc("R12 rd63",  6'd32, 6'd0, 3'b000, 0, 3'd4, 0);
        cyc("R6 big",    6'd32, 6'd0, 3'b000, 0, 3'd0, 0);
        cyc("R12 rx0",   6'd0, 6'd0, 3'b000, 1, 3'd5, 32'h40);
        cyc("R5 zero",   6'd0, 6'd0, 3'b000, 0, 3'd0, 0);
        cyc("R12 tx0",   6'd0, 6'd0, 3'b000, 1, 3'd4, 32'h0);
        cyc("R6 zero",   6'd0, 6'd0, 3'b000, 0, 3'd0, 0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] tx, rx;
            logic [2:0] ev, a;
            logic       we;
            logic [31:0] d;
            tx = ($urandom % 4 == 0) ? ((i % 2) ? 6'd32 : 6'd0) : 6'($urandom % 33);
            rx = ($urandom % 4 == 0) ? ((i % 3) ? 6'd32 : 6'd0) : 6'($urandom % 33);
            ev = {($urandom % 8 == 0), ($urandom % 8 == 0), ($urandom % 8 == 0)};
            we = ($urandom % 3 == 0);
            a  = 3'($urandom % 8);
            d  = $urandom;
            if (a == 3'd4 || a == 3'd5) d[5:0] = 6'($urandom % 40);
            cyc(tag_of(a), tx, rx, ev, we, a, d);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule